// File: doc/BRIEF.md
# Register-Pair Bitfield Extractor

This unit pulls a bitfield out of a 64-bit value made from two 32-bit data words and returns it as a 32-bit word. A third 32-bit word, the descriptor, carries both the bit position where the field starts and the number of bits it spans. A two-bit layout code tells the unit where those two numbers sit inside the descriptor. A sign control chooses whether the field is sign-extended or zero-extended into the result.

The unit is a single pipeline stage. A valid strobe comes in with the operands, and the result appears together with its own valid flag one clock later. The pipeline that feeds it does the instruction decode, reads the register file and picks the register pair. The unit itself sees only the three words, the layout code and the sign control.

Top module: `pair_field_extract`

## Requirements
- R1: The source is `{src_hi, src_lo}`, with `src_hi` in bits 63:32. It is shifted right logically by the 6-bit start offset (0..63), and zeros fill in from above bit 63.
- R2: Layout code 0 takes the width from descriptor bits 21:16 and the start offset from bits 5:0. Code 3 behaves exactly like code 0.
- R3: Layout code 1 takes the width from descriptor bits 13:8 and the start offset from bits 5:0.
- R4: Layout code 2 takes the width from descriptor bits 29:24 and the start offset from bits 21:16.
- R5: A 6-bit width field above 32 acts as 32. Any width field with bit 5 set therefore gives a full 32-bit field.
- R6: An effective width of 0 gives a result of 0, whatever the sign control is set to.
- R7: When `sign_ext` is 0, result bits at or above the effective width are 0.
- R8: When `sign_ext` is 1, result bits at or above the effective width copy bit (width-1) of the field. Bits below the width are the shifted source bits in both modes.
- R9: `out_valid` is `in_valid` delayed by one clock. `result` changes only on a clock that follows a cycle in which `in_valid` was high, and otherwise holds its value.
- R10: A synchronous active-high `rst` clears `out_valid` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src_lo | input | 32 | Low word of the source pair |
| src_hi | input | 32 | High word of the source pair |
| desc | input | 32 | Descriptor holding the width and start offset |
| layout | input | 2 | Descriptor layout: 0 plain, 1 packed low, 2 packed high, 3 same as 0 |
| sign_ext | input | 1 | 1 sign-extends the field, 0 zero-extends it |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Extracted field |

## Verification
Every result and its valid flag are due exactly one clock after the cycle in which the operands are presented. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, so each sample falls halfway after the single register stage. The sweep presents a new operand set every cycle, which checks back-to-back issue at that one-cycle distance. The hold and idle checks leave `in_valid` low for one cycle and then read the outputs on the falling edge that follows.

// File: rtl/pair_field_extract.sv
module pair_field_extract #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] src_lo,
  input  logic [W-1:0] src_hi,
  input  logic [W-1:0] desc,
  input  logic [1:0]   layout,
  input  logic         sign_ext,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int OFS_W = $clog2(2 * W);
  localparam int WID_W = $clog2(W) + 1;
  localparam int PL_WID = 16;
  localparam int PL_OFS = 0;
  localparam int LO_WID = 8;
  localparam int LO_OFS = 0;
  localparam int HI_WID = 24;
  localparam int HI_OFS = 16;
  localparam logic [WID_W:0] FULL = (WID_W + 1)'(W);

  logic [WID_W-1:0] wid_raw, wid_eff;
  logic [OFS_W-1:0] ofs;
  logic [2*W-1:0]   shifted;
  logic [W-1:0]     mask, field, top_bit, ext_val;
  logic             fill;

  always_comb begin
    case (layout)
      2'd1: begin
        wid_raw = desc[LO_WID +: WID_W];
        ofs     = desc[LO_OFS +: OFS_W];
      end
      2'd2: begin
        wid_raw = desc[HI_WID +: WID_W];
        ofs     = desc[HI_OFS +: OFS_W];
      end
      default: begin
        wid_raw = desc[PL_WID +: WID_W];
        ofs     = desc[PL_OFS +: OFS_W];
      end
    endcase
  end

  assign wid_eff = ({1'b0, wid_raw} > FULL) ? FULL[WID_W-1:0] : wid_raw;
  assign shifted = {src_hi, src_lo} >> ofs;
  assign mask    = {W{1'b1}} >> (FULL - {1'b0, wid_eff});
  assign field   = shifted[W-1:0] & mask;
  assign top_bit = mask & ~(mask >> 1);
  assign fill    = sign_ext & (|(field & top_bit));
  assign ext_val = field | ({W{fill}} & ~mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= ext_val;
    end
  end
endmodule

// File: rtl/pair_field_extract_chk.sv
module pair_field_extract_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] desc,
  input logic [1:0]   layout,
  input logic         sign_ext,
  input logic         out_valid,
  input logic [W-1:0] result
);
  logic [6:0] w_now, w_q;
  logic       s_q;
  logic [5:0] wf;

  always_comb begin
    case (layout)
      2'd1:    wf = desc[13:8];
      2'd2:    wf = desc[29:24];
      default: wf = desc[21:16];
    endcase
    w_now = (wf > 6'd32) ? 7'd32 : {1'b0, wf};
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      w_q <= w_now;
      s_q <= sign_ext;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && result == '0)); // R10
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) (!in_valid && !$past(rst)) |=> $stable(result)); // R9
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst) (in_valid && w_now == 7'd0) |=> result == '0); // R6
  AST_UNSIGNED_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !s_q && w_q < 7'd32) |-> ((result >> w_q) == '0)); // R7
  AST_SIGNED_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s_q && w_q != 7'd0 && w_q < 7'd32) |->
    (W'($signed(result << (7'd32 - w_q)) >>> (7'd32 - w_q)) == result)); // R8
endmodule

bind pair_field_extract pair_field_extract_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .desc(desc), .layout(layout),
  .sign_ext(sign_ext), .out_valid(out_valid), .result(result)
);

// File: tb/pair_field_extract_bench.sv
`timescale 1ns/1ps
module pair_field_extract_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0, desc = '0;
  logic [1:0]  layout = '0;
  logic        sign_ext = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pair_field_extract u_pair_field_extract (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_lo(src_lo), .src_hi(src_hi),
    .desc(desc), .layout(layout), .sign_ext(sign_ext),
    .out_valid(out_valid), .result(result)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] lo, logic [31:0] hi,
                                        logic [31:0] d, logic [1:0] lay, logic s);
    longint unsigned src, v, span;
    int w, off;
    case (lay)
      2'd1: begin w = int'(d[13:8]);  off = int'(d[5:0]);   end
      2'd2: begin w = int'(d[29:24]); off = int'(d[21:16]); end
      default: begin w = int'(d[21:16]); off = int'(d[5:0]); end
    endcase
    if (w > 32) w = 32;
    if (w == 0) return 32'd0;
    src  = {hi, lo};
    v    = src / (64'd1 << off);
    span = 64'd1 << w;
    v    = v % span;
    if (s && v >= (span >> 1)) v = v - span;
    return v[31:0];
  endfunction

  function automatic logic [31:0] mk_desc(logic [31:0] fill, logic [1:0] lay, int w, int off);
    logic [31:0] d = fill;
    case (lay)
      2'd1: begin d[13:8] = 6'(w);  d[5:0] = 6'(off);   end
      2'd2: begin d[29:24] = 6'(w); d[21:16] = 6'(off); end
      default: begin d[21:16] = 6'(w); d[5:0] = 6'(off); end
    endcase
    return d;
  endfunction

  task automatic one(string tag, logic [31:0] lo, logic [31:0] hi,
                     logic [31:0] d, logic [1:0] lay, logic s);
    src_lo = lo; src_hi = hi; desc = d; layout = lay; sign_ext = s; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk({tag, " valid R9"}, {31'd0, out_valid}, 32'd1);
    chk(tag, result, model(lo, hi, d, lay, s));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset result", result, 32'd0);

    one("R1 top bit only", 32'h0, 32'h8000_0000, mk_desc(0, 2'd0, 32, 63), 2'd0, 1'b0);
    chk("R1 offset63 unsigned", result, 32'd1);
    one("R1 top bit signed", 32'h0, 32'h8000_0000, mk_desc(0, 2'd0, 32, 63), 2'd0, 1'b1);
    chk("R1 offset63 signed", result, 32'd1);
    one("R5 clamp", 32'h1234_5678, 32'h9abc_def0, mk_desc(32'hffff_ffff, 2'd1, 45, 16), 2'd1, 1'b0);
    chk("R5 clamp value", result, 32'hdef0_1234);
    one("R6 zero width signed", 32'hffff_ffff, 32'hffff_ffff, mk_desc(32'hffff_ffff, 2'd2, 0, 5), 2'd2, 1'b1);
    chk("R6 zero value", result, 32'd0);
    one("R8 sign fill", 32'h0000_0080, 32'h0, mk_desc(0, 2'd0, 8, 0), 2'd0, 1'b1);
    chk("R8 sign value", result, 32'hffff_ff80);
    one("R7 zero fill", 32'h0000_0080, 32'h0, mk_desc(0, 2'd0, 8, 0), 2'd0, 1'b0);
    chk("R7 zero value", result, 32'h0000_0080);

    held = result;
    in_valid = 1'b0; src_lo = 32'hdead_beef; desc = 32'h0010_0000;
    @(posedge clk); @(negedge clk);
    chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R9 hold result", result, held);

    for (int lay = 0; lay < 4; lay++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 64; w++)
          for (int off = 0; off < 64; off++) begin
            string t;
            t = (lay == 1) ? "R3" : (lay == 2) ? "R4" : "R2";
            t = {t, (s != 0) ? " R8" : " R7"};
            if (w > 32) t = {t, " R5"};
            if (w == 0) t = {t, " R6"};
            if (off > 31) t = {t, " R1"};
            one(t, $urandom, $urandom, mk_desc($urandom, 2'(lay), w, off), 2'(lay), s[0]);
          end

    rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 midstream valid", {31'd0, out_valid}, 32'd0);
    chk("R10 midstream result", result, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule